// File: doc/BRIEF.md
# Two-Wire Serial Slave with Register Pointer Access

This block is a slave on a two-wire I2C bus. It lets a host reach a bank of 8-bit control registers held outside the block. The block watches SCL and SDA, finds START and STOP conditions and answers to one fixed 7-bit device address. The last bit of the first byte chooses between a write and a read.

A write transfer carries a one-byte register sub-address and then any number of data bytes. The data bytes go to consecutive registers. A read transfer carries no sub-address. It returns bytes starting at the pointer left by the most recent write, and the pointer moves on by one after every byte. The 8-bit pointer wraps from 0xFF to 0x00.

SDA is driven only through an open-drain pull-down enable. The register bank is reached through a one-cycle write strobe with its own address and data, and through a combinational read port addressed by the live pointer.

Top module: `i2c_regport_slave`

## Requirements
- R1: A first byte whose upper seven bits equal the device address (default 7'h40) is acknowledged by pulling SDA low during the ninth SCL high period. Byte bit 0 selects the direction: 0 means write and 1 means read.
- R2: When the first byte carries any other address, the block never pulls SDA low and does not strobe a write until the next START or STOP.
- R3: In a write transfer, the second byte loads the pointer. Each later byte gives exactly one single-cycle `reg_we_o` pulse, with `reg_waddr_o` equal to the pointer and `reg_wdata_o` equal to the byte. The pointer then reads as the written address plus one. Every received byte is acknowledged.
- R4: A read transfer returns `reg_rdata_i` for the current pointer, most significant bit first, with no sub-address byte.
- R5: After each byte read, the pointer advances by one. While the master acknowledges, the next byte comes from the new pointer.
- R6: After the master does not acknowledge a read byte, the block leaves SDA released until the next START or STOP.
- R7: A repeated START returns the block to address reception and keeps the stored pointer.
- R8: The pointer wraps from 0xFF to 0x00, both when writing and when reading.
- R9: A STOP releases SDA and returns the block to idle.
- R10: During and after reset, `sda_oe_o` and `reg_we_o` are 0 and `reg_raddr_o` is 0.
- R11: The block changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_waddr_o | output | 8 | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| reg_raddr_o | output | 8 | Live pointer, used as the register read address |
| reg_rdata_i | input | 8 | Register read data for `reg_raddr_o` |

## Verification
The hardest state to reach is the pointer sitting at 0xFF when a transfer crosses into 0x00. The stimulus reaches it twice. First, a write loads sub-address 0xFE and runs three data bytes past the top. Then a write of sub-address 0xFF alone is followed by a separate two-byte read. The repeated START test follows a multi-byte write, so the pointer it must keep is one the data phase has moved, not the one the sub-address loaded. A foreign address is sent together with trailing bytes, and the bench watches every clock that nothing pulls SDA low.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s_o    = scl_ff[STAGES-1];
  assign sda_s_o    = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  // data edge while clock stays high
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              drive_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              quiet_o
);
  localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);

  i2cs_state_e       st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] ptr;
  logic              rw, more, drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      more    <= 1'b0;
      drive   <= 1'b0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        st    <= ST_ADDR;
        cnt   <= '0;
        drive <= 1'b0;
      end else if (stop_i) begin
        st    <= ST_IDLE;
        drive <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (rise_i && cnt != BITS_FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s_i};
              cnt <= cnt + 1'b1;
            end else if (fall_i && cnt == BITS_FULL) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                  rw    <= sh[0];
                  drive <= 1'b1;
                  st    <= ST_ADDR_ACK;
                end else begin
                  st <= ST_IGNORE;
                end
              end else if (st == ST_SUB) begin
                ptr   <= sh;
                drive <= 1'b1;
                st    <= ST_SUB_ACK;
              end else begin
                we_o    <= 1'b1;
                waddr_o <= ptr;
                wdata_o <= sh;
                ptr     <= ptr + 1'b1;
                drive   <= 1'b1;
                st      <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (fall_i) begin
              cnt <= '0;
              if (rw) begin
                sh    <= rdata_i;
                drive <= ~rdata_i[BYTE_W-1];
                st    <= ST_RDATA;
              end else begin
                drive <= 1'b0;
                st    <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: begin
            if (fall_i) begin
              drive <= 1'b0;
              st    <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (fall_i) begin
              if (cnt == BITS_LAST) begin
                cnt   <= '0;
                drive <= 1'b0;
                ptr   <= ptr + 1'b1;
                st    <= ST_RACK;
              end else begin
                sh    <= {sh[BYTE_W-2:0], 1'b0};
                drive <= ~sh[BYTE_W-2];
                cnt   <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (rise_i) begin
              more <= ~sda_s_i;
            end else if (fall_i) begin
              if (more) begin
                sh    <= rdata_i;
                drive <= ~rdata_i[BYTE_W-1];
                st    <= ST_RDATA;
              end else begin
                st <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign drive_o = drive;
  assign ptr_o   = ptr;
  assign quiet_o = (st == ST_IGNORE);
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic        reg_we_o,
  output logic [7:0]  reg_waddr_o,
  output logic [7:0]  reg_wdata_o,
  output logic [7:0]  reg_raddr_o,
  input  logic [7:0]  reg_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_s, stop_s, quiet;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_s),
    .stop_o     (stop_s)
  );

  i2cs_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sda_s_i (sda_s),
    .rise_i  (scl_rise),
    .fall_i  (scl_fall),
    .start_i (start_s),
    .stop_i  (stop_s),
    .rdata_i (reg_rdata_i),
    .drive_o (sda_oe_o),
    .we_o    (reg_we_o),
    .waddr_o (reg_waddr_o),
    .wdata_o (reg_wdata_o),
    .ptr_o   (reg_raddr_o),
    .quiet_o (quiet)
  );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       start_s,
  input logic       stop_s,
  input logic       quiet,
  input logic       sda_oe_o,
  input logic       reg_we_o,
  input logic [7:0] reg_waddr_o,
  input logic [7:0] reg_raddr_o
);
  // R11
  sda_change_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> (!scl_s || $past(start_s || stop_s)));
  // R3
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_raddr_o == 8'(reg_waddr_o + 8'd1));
  // R9
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_s |=> !sda_oe_o);
  // R7
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_s |=> !sda_oe_o);
  // R2
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |-> (!sda_oe_o && !reg_we_o));
endmodule

bind i2c_regport_slave i2cs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_s       (scl_s),
  .start_s     (start_s),
  .stop_s      (stop_s),
  .quiet       (quiet),
  .sda_oe_o    (sda_oe_o),
  .reg_we_o    (reg_we_o),
  .reg_waddr_o (reg_waddr_o),
  .reg_raddr_o (reg_raddr_o)
);

// File: tb/sim_i2c_regport_slave.sv
`timescale 1ns/1ps
module sim_i2c_regport_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, we;
  logic [7:0] waddr, wdata, raddr, rdata;
  logic sda_bus;
  logic [7:0] rf [256];
  logic [7:0] em [256];
  logic [15:0] wq [$];
  logic [7:0] exp_ptr;
  int n_chk = 0, n_err = 0, quiet_viol = 0;
  bit quiet_on = 0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign rdata = rf[raddr];

  i2c_regport_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_we_o(we), .reg_waddr_o(waddr),
    .reg_wdata_o(wdata), .reg_raddr_o(raddr), .reg_rdata_i(rdata)
  );

  initial for (int i = 0; i < 256; i++) begin
    rf[i] = 8'(i) ^ 8'h5A;
    em[i] = 8'(i) ^ 8'h5A;
  end
  always @(posedge clk) if (we) rf[waddr] <= wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) if (rst_n) begin
    if (we) begin
      if (wq.size() == 0) chk(0, "R3 unexpected write", {waddr, wdata}, 0);
      else begin
        logic [15:0] e;
        e = wq.pop_front();
        chk({waddr, wdata} == e, "R3 write addr/data", {waddr, wdata}, e);
      end
    end
    if (quiet_on && sda_oe) quiet_viol++;
  end

  task automatic half();
    repeat (10) @(negedge clk);
  endtask

  task automatic i_start();
    sda_m = 1; half(); scl = 1; half(); sda_m = 0; half(); scl = 0; half();
  endtask

  task automatic i_stop();
    sda_m = 0; half(); scl = 1; half(); sda_m = 1; half();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl = 1; half(); scl = 0;
    end
    sda_m = 1; half(); scl = 1;
    repeat (5) @(negedge clk);
    ack = ~sda_bus;
    repeat (5) @(negedge clk);
    scl = 0; half();
  endtask

  task automatic recv(output logic [7:0] b, input logic ack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      half(); scl = 1;
      repeat (5) @(negedge clk);
      b[i] = sda_bus;
      repeat (5) @(negedge clk);
      scl = 0;
    end
    sda_m = ~ack; half(); scl = 1; half(); scl = 0; half(); sda_m = 1;
  endtask

  task automatic wr_byte(input logic [7:0] d, input string req);
    logic a;
    wq.push_back({exp_ptr, d});
    em[exp_ptr] = d;
    exp_ptr = exp_ptr + 8'd1;
    send(d, a);
    chk(a == 1, req, a, 1);
  endtask

  task automatic rd_byte(input logic ack, input string req);
    logic [7:0] b;
    recv(b, ack);
    chk(b == em[exp_ptr], req, b, em[exp_ptr]);
    exp_ptr = exp_ptr + 8'd1;
  endtask

  task automatic quiet_begin();
    quiet_viol = 0; quiet_on = 1;
  endtask

  task automatic quiet_end(input string req);
    quiet_on = 0;
    chk(quiet_viol == 0, req, quiet_viol, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic a;
    exp_ptr = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sda_oe == 0, "R10 sda_oe in reset", sda_oe, 0);
    chk(we == 0, "R10 we in reset", we, 0);
    chk(raddr == 0, "R10 pointer in reset", raddr, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0 && raddr == 0, "R10 after reset", {sda_oe, raddr}, 0);

    // R1 R3 write two bytes from 0x10
    i_start();
    send(8'h80, a); chk(a == 1, "R1 write address ack", a, 1);
    send(8'h10, a); chk(a == 1, "R3 sub-address ack", a, 1);
    exp_ptr = 8'h10;
    wr_byte(8'hA5, "R3 data ack");
    wr_byte(8'h3C, "R3 data ack");
    i_stop();
    repeat (5) @(negedge clk);
    chk(sda_oe == 0, "R9 released after stop", sda_oe, 0);
    chk(raddr == 8'h12, "R3 pointer after writes", raddr, 8'h12);

    // R4 R5 R6 read without sub-address: continues at 0x12
    i_start();
    send(8'h81, a); chk(a == 1, "R1 read address ack", a, 1);
    rd_byte(1, "R4 first read byte");
    rd_byte(1, "R5 second read byte");
    rd_byte(0, "R5 third read byte nacked");
    quiet_begin();
    half(); scl = 1; half(); scl = 0; half();
    quiet_end("R6 released after nack");
    quiet_begin();
    i_stop();
    quiet_end("R9 stop after read");

    // R2 foreign address with trailing bytes
    i_start();
    quiet_begin();
    send(8'h84, a); chk(a == 0, "R2 no ack on foreign address", a, 0);
    send(8'h00, a); send(8'hFF, a);
    quiet_end("R2 bus untouched");
    i_stop();
    chk(wq.size() == 0, "R2 no write strobes", wq.size(), 0);
    chk(raddr == exp_ptr, "R2 pointer unchanged", raddr, exp_ptr);

    // R8 write wrap from 0xFE, then R7 repeated start keeps pointer
    i_start();
    send(8'h80, a); chk(a == 1, "R1 address ack", a, 1);
    send(8'hFE, a); chk(a == 1, "R3 sub-address ack", a, 1);
    exp_ptr = 8'hFE;
    wr_byte(8'h11, "R8 write at 0xFE");
    wr_byte(8'h22, "R8 write at 0xFF");
    wr_byte(8'h33, "R8 write wraps to 0x00");
    i_start();
    send(8'h81, a); chk(a == 1, "R7 address ack after repeated start", a, 1);
    rd_byte(0, "R7 read keeps pointer 0x01");
    i_stop();

    // R8 read wrap: set pointer to 0xFF with no data
    i_start();
    send(8'h80, a); send(8'hFF, a); chk(a == 1, "R3 sub-address only", a, 1);
    exp_ptr = 8'hFF;
    i_stop();
    i_start();
    send(8'h81, a); chk(a == 1, "R1 read address ack", a, 1);
    rd_byte(1, "R8 read 0xFF");
    rd_byte(0, "R8 read wraps to 0x00");
    i_stop();
    repeat (5) @(negedge clk);
    chk(raddr == 8'h01, "R8 pointer after read wrap", raddr, 8'h01);
    chk(wq.size() == 0, "R3 all writes seen", wq.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule